// File: doc/BRIEF.md
# Feature Unlock Sequence Detector

This block guards the extended features of a video/memory controller behind a deliberately unlikely series of byte writes. It observes each byte the processor writes to the display controller's address-register port and keeps a single flag that reports whether the extended features are open. Existing software that never produces the series cannot reach the extended register page or the secondary ROM mapping register by accident.

An attempt begins with a synchronisation step: any nonzero byte, then a zero byte. A fixed fifteen-byte key must follow. If the last byte is the expected final key byte, the flag opens. If the first fourteen bytes are correct and the last one is anything else, the flag closes. A wrong byte earlier in the key abandons the attempt and leaves the flag unchanged. Every attempt, whether it completes or is abandoned, needs a new synchronisation step. The flag also gates write requests to the secondary mapping register. A debug output exposes the detector's position in the series.

Top module: `xfeat_unlock`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears `unlocked` to 0 and sets `dbg_state` to 0 (waiting for synchronisation).
- R2: A clock edge with `wr_en` low changes neither `unlocked` nor `dbg_state`, whatever `wr_data` holds.
- R3: In state 0, a nonzero byte moves the detector to state 1 (armed) and a zero byte leaves it in state 0. In state 1, a zero byte moves it to state 2 and a nonzero byte leaves it in state 1.
- R4: State 2+n (n = 0..14) expects key byte n of the series FF,77,B3,51,A8,D4,62,39,9C,46,2B,15,8A,CD,EE. A matching byte for n < 14 advances to state 3+n. A matching final byte (EE, at n = 14) sets `unlocked` to 1 and returns to state 0.
- R5: In state 16 (n = 14), any byte other than EE clears `unlocked` to 0 and returns to state 0.
- R6: A byte that does not match in states 2 to 15 returns the detector to state 0 and leaves `unlocked` unchanged.
- R7: After a completed series, another series only takes effect once a new synchronisation is done. A key sent without synchronisation leaves `unlocked` unchanged.
- R8: `map_wr_ok` equals `map_wr_req` while `unlocked` is 1 and is 0 while `unlocked` is 0, in the same cycle.
- R9: `unlocked` changes only on the clock edge that takes the byte written in state 16, or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Strobe for a write to the display controller's address-register port |
| wr_data | input | 8 | Byte written with the strobe |
| map_wr_req | input | 1 | Write request to the secondary ROM mapping register |
| unlocked | output | 1 | 1 when the extended features are open |
| map_wr_ok | output | 1 | Mapping-register write request, passed only while unlocked |
| dbg_state | output | 5 | Detector position: 0 waiting, 1 armed, 2+n expecting key byte n |

## Verification
The bench sends the key with no synchronisation first, which separates a detector that needs the nonzero-then-zero step from one that accepts the key at any time. It also sends the full key to open the lock and the key with a foreign final byte to close it again, which shows that only the last byte decides the direction. It breaks the key at an early position and at the last position before the end, which shows that an abandoned attempt keeps the flag and returns to waiting. Idle cycles with changing data, and mapping requests made in both flag states, cover the strobe qualification and the gating.

// File: rtl/unlock_pkg.sv
// Shared constants for the feature unlock detector.
// Assumes byte-wide writes; the key is computed through a function, not stored.
package unlock_pkg;
    localparam int DW      = 8;
    localparam int KEY_LEN = 15;
    // states: wait, armed, then one per key byte
    localparam int ST_W    = $clog2(KEY_LEN + 2);

    // Returns key byte i of the unlock series.
    function automatic logic [DW-1:0] key_byte(input int i);
        case (i)
            0:  key_byte = 8'hFF;
            1:  key_byte = 8'h77;
            2:  key_byte = 8'hB3;
            3:  key_byte = 8'h51;
            4:  key_byte = 8'hA8;
            5:  key_byte = 8'hD4;
            6:  key_byte = 8'h62;
            7:  key_byte = 8'h39;
            8:  key_byte = 8'h9C;
            9:  key_byte = 8'h46;
            10: key_byte = 8'h2B;
            11: key_byte = 8'h15;
            12: key_byte = 8'h8A;
            13: key_byte = 8'hCD;
            14: key_byte = 8'hEE;
            default: key_byte = '0;
        endcase
    endfunction
endpackage

// File: rtl/unlock_seq_fsm.sv
// Sequence tracker: follows the sync step and the key bytes.
// Emits a one-cycle 'fin' on the byte taken in the last key position and
// 'fin_open' when that byte is the final key byte. Assumes wr_en is already
// qualified by the port decode.
module unlock_seq_fsm
    import unlock_pkg::*;
#(
    parameter int KLEN = KEY_LEN,
    parameter int SW   = ST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [SW-1:0] state,
    output logic          fin,
    output logic          fin_open
);
    localparam int S_WAIT = 0;
    localparam int S_ARM  = 1;
    localparam int S_K0   = 2;
    localparam int S_LAST = S_K0 + KLEN - 1;

    logic [KLEN-1:0] match;
    logic [SW-1:0]   nxt;
    int              kidx;

    // One comparator per key position.
    for (genvar g = 0; g < KLEN; g++) begin : g_cmp
        assign match[g] = (wr_data == key_byte(g));
    end

    assign kidx = int'(state) - S_K0;

    // Next-state decision for each accepted byte.
    always_comb begin
        nxt      = state;
        fin      = 1'b0;
        fin_open = 1'b0;
        if (wr_en) begin
            if (int'(state) == S_WAIT) begin
                nxt = (wr_data != '0) ? SW'(S_ARM) : SW'(S_WAIT);
            end else if (int'(state) == S_ARM) begin
                nxt = (wr_data == '0) ? SW'(S_K0) : SW'(S_ARM);
            end else if (int'(state) == S_LAST) begin
                fin      = 1'b1;
                fin_open = match[KLEN-1];
                nxt      = SW'(S_WAIT);
            end else if (kidx >= 0 && kidx < KLEN - 1) begin
                nxt = match[kidx] ? state + SW'(1) : SW'(S_WAIT);
            end else begin
                nxt = SW'(S_WAIT);
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SW'(S_WAIT);
        else        state <= nxt;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state)); // R2
    AST_ARM_ON_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(state) == S_WAIT && wr_data != '0) |=> int'(state) == S_ARM); // R3
    AST_SYNC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(state) == S_ARM && wr_data == '0) |=> int'(state) == S_K0); // R3
    AST_END_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> int'(state) == S_WAIT); // R7
    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(state) <= S_LAST); // R4
endmodule

// File: rtl/unlock_flag.sv
// Holds the unlocked flag. It loads a new value only when the tracker
// reports a finished series. Assumes 'fin' is a single-cycle pulse.
module unlock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fin,
    input  logic fin_open,
    output logic unlocked
);
    // Flag register: cleared by reset, loaded at series end.
    always_ff @(posedge clk) begin
        if (!rst_n)   unlocked <= 1'b0;
        else if (fin) unlocked <= fin_open;
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(unlocked)); // R9
    AST_CLOSE_ON_BAD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !fin_open) |=> !unlocked); // R5
    AST_OPEN_ON_GOOD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && fin_open) |=> unlocked); // R4
endmodule

// File: rtl/xfeat_unlock.sv
// Top of the feature unlock detector. Connects the sequence tracker to the
// flag register and gates mapping-register writes with the flag.
// Assumes all inputs are synchronous to clk.
module xfeat_unlock
    import unlock_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            map_wr_req,
    output logic            unlocked,
    output logic            map_wr_ok,
    output logic [ST_W-1:0] dbg_state
);
    logic fin;
    logic fin_open;

    unlock_seq_fsm #(.KLEN(KEY_LEN), .SW(ST_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .state(dbg_state), .fin(fin), .fin_open(fin_open)
    );

    unlock_flag u_flag (
        .clk(clk), .rst_n(rst_n), .fin(fin), .fin_open(fin_open),
        .unlocked(unlocked)
    );

    // Mapping writes pass only while the features are open.
    always_comb map_wr_ok = map_wr_req & unlocked;

    AST_RESET_LOCKS: assert property (@(posedge clk)
        !rst_n |=> (!unlocked && dbg_state == '0)); // R1
    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !map_wr_ok); // R8
endmodule

// File: tb/sim_xfeat_unlock.sv
module sim_xfeat_unlock;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       map_wr_req = 1'b0;
    logic       unlocked;
    logic       map_wr_ok;
    logic [4:0] dbg_state;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    byte unsigned key [15] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
                               8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

    // reference model state: 0 wait, 1 armed, 2+n expecting key[n]
    int m_st = 0;
    int m_flag = 0;

    always #2.5 clk = ~clk;

    xfeat_unlock u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .map_wr_req(map_wr_req), .unlocked(unlocked), .map_wr_ok(map_wr_ok),
        .dbg_state(dbg_state)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_flag = 0;
        end else if (wr_en) begin
            if (m_st == 0)      m_st = (wr_data != 0) ? 1 : 0;
            else if (m_st == 1) m_st = (wr_data == 0) ? 2 : 1;
            else if (m_st == 16) begin
                m_flag = (wr_data == key[14]) ? 1 : 0;
                m_st = 0;
            end else m_st = (wr_data == key[m_st-2]) ? m_st + 1 : 0;
        end
    end

    // compare with the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!done && rst_n) begin
            chk(int'(unlocked) == m_flag, "R4/R5/R6 model flag", int'(unlocked), m_flag);
            chk(int'(dbg_state) == m_st, "R3/R4 model state", int'(dbg_state), m_st);
            chk(map_wr_ok == (map_wr_req && m_flag == 1), "R8 model gate",
                int'(map_wr_ok), int'(map_wr_req && m_flag == 1));
        end
    end

    task automatic wr(input byte unsigned b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic sync_step();
        wr(8'h5A); wr(8'h00);
    endtask

    task automatic send_key(input int upto, input byte unsigned last);
        for (int i = 0; i < upto; i++) wr(key[i]);
        wr(last);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(unlocked == 1'b0, "R1 flag after reset", int'(unlocked), 0);
        chk(dbg_state == 5'd0, "R1 state after reset", int'(dbg_state), 0);
        map_wr_req = 1'b1; #0.1;
        chk(map_wr_ok == 1'b0, "R8 gate closed", int'(map_wr_ok), 0);
        map_wr_req = 1'b0;

        wr(8'h00);
        chk(dbg_state == 5'd0, "R3 zero while waiting", int'(dbg_state), 0);

        // R9 / R7: key without sync
        send_key(14, key[14]);
        chk(unlocked == 1'b0, "R7 key without sync", int'(unlocked), 0);
        chk(dbg_state == 5'd1, "R3 nonzero keeps armed", int'(dbg_state), 1);

        // R2: data changing with strobe low
        @(negedge clk); wr_data = 8'h00;
        @(negedge clk); wr_data = 8'hFF;
        @(negedge clk);
        chk(dbg_state == 5'd1, "R2 strobe low ignored", int'(dbg_state), 1);

        wr(8'h00);
        chk(dbg_state == 5'd2, "R3 sync completes", int'(dbg_state), 2);
        for (int i = 0; i < 5; i++) wr(key[i]);
        chk(dbg_state == 5'd7, "R4 key position", int'(dbg_state), 7);
        for (int i = 5; i < 15; i++) wr(key[i]);
        chk(unlocked == 1'b1, "R4 full key opens", int'(unlocked), 1);
        chk(dbg_state == 5'd0, "R4 back to wait", int'(dbg_state), 0);
        map_wr_req = 1'b1; #0.1;
        chk(map_wr_ok == 1'b1, "R8 gate open", int'(map_wr_ok), 1);
        map_wr_req = 1'b0;

        // R7: closing key without resync has no effect
        send_key(14, 8'h12);
        chk(unlocked == 1'b1, "R7 no resync no relock", int'(unlocked), 1);

        // R6: early break keeps flag
        wr(8'h00); // leaves armed state 1 -> 2
        wr(key[0]); wr(key[1]); wr(8'h00);
        chk(dbg_state == 5'd0, "R6 early break to wait", int'(dbg_state), 0);
        chk(unlocked == 1'b1, "R6 early break keeps flag", int'(unlocked), 1);

        // R6: break at position 13
        sync_step();
        send_key(13, 8'h00);
        chk(dbg_state == 5'd0, "R6 late break to wait", int'(dbg_state), 0);
        chk(unlocked == 1'b1, "R6 late break keeps flag", int'(unlocked), 1);

        // R5: relock with foreign final byte
        sync_step();
        send_key(14, 8'h12);
        chk(unlocked == 1'b0, "R5 relock", int'(unlocked), 0);
        chk(dbg_state == 5'd0, "R5 back to wait", int'(dbg_state), 0);

        // reopen then reset
        sync_step();
        send_key(14, key[14]);
        chk(unlocked == 1'b1, "R4 reopen", int'(unlocked), 1);
        wr(8'h33);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(unlocked == 1'b0, "R1 reset relocks", int'(unlocked), 0);
        chk(dbg_state == 5'd0, "R1 reset to wait", int'(dbg_state), 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule